// File: doc/BRIEF.md
# Secure Loader Region Guard

This block screens memory and configuration requests during secure startup. It protects one 64 KB window of physical memory, aligned to 64 KB. The window's base is held in a register that no software path can read or write. A secure-initialization event loads that register from a dedicated load input.

Each request is tagged with three flags:
- whether it comes from an external device or from the CPU;
- whether its address was produced by graphics-aperture translation;
- whether it targets configuration space instead of memory.

While the guard is enabled, it blocks three kinds of request:
- device memory requests that land in the window;
- aperture-translated memory requests that land in the window, from any origin;
- every device configuration request, at any address.

Each decision appears one cycle after the request. A blocked request also produces a single-cycle violation pulse that carries the offending address to an error logger.

Top module: `sl_region_guard`

## Requirements
- R1: After reset the stored window base is zero, `resp_valid` is 0 and `viol_pulse` is 0.
- R2: A cycle with `init_load` high stores `init_base` (address bits [39:16]) as the new window base. A memory address is in the window when its bits [39:16] equal the stored base; bits [15:0] play no part.
- R3: With `guard_en` high, a request with `req_from_dev`=1 and `req_cfg`=0 whose address is in the window is blocked.
- R4: With `guard_en` high, a request with `req_aperture`=1 and `req_cfg`=0 whose address is in the window is blocked, whatever `req_from_dev` is.
- R5: With `guard_en` high, a request with `req_from_dev`=1 and `req_cfg`=1 is blocked at any address.
- R6: With `guard_en` high, all other requests are allowed. These are:
  - CPU memory requests that are not aperture-translated, at any address;
  - CPU configuration requests, where the aperture flag is ignored;
  - memory requests outside the window.
- R7: With `guard_en` low, every request is allowed.
- R8: The decision for a request sampled with `req_valid`=1 appears on the next cycle. At that point `resp_valid`=1 and `resp_block`=1 means blocked. `viol_pulse` is high for exactly that cycle when the request is blocked, and `viol_addr` then holds the request address.
- R9: In a cycle after one with `req_valid`=0, `resp_valid`, `resp_block` and `viol_pulse` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| guard_en | input | 1 | Guard enable from the control register |
| init_load | input | 1 | Secure-initialization event; loads the window base |
| init_base | input | 24 | Window base, address bits [39:16] |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 40 | Request physical address |
| req_from_dev | input | 1 | 1 = external device, 0 = CPU |
| req_aperture | input | 1 | 1 = address came through aperture translation |
| req_cfg | input | 1 | 1 = configuration space, 0 = memory |
| resp_valid | output | 1 | Decision present |
| resp_block | output | 1 | 1 = request blocked |
| viol_pulse | output | 1 | One-cycle pulse for a blocked request |
| viol_addr | output | 40 | Address of the blocked request |

## Verification
The window edges matter most. The bench probes the first and last byte of the window and the bytes just outside it. A design that compares too few or too many address bits either lets part of the window leak or blocks a neighbouring page.

Aperture requests from the CPU are a key case, because a guard that keys only on device origin would allow them. CPU configuration requests are another: a guard that blocks all configuration traffic would stall the CPU's own setup.

Reloading the base must move protection off the old window. Disabling the guard must release every class of request. Idle cycles must leave a stale pulse behind none of these checks.

// File: rtl/sl_region_guard.sv
module sl_region_guard #(
  parameter int ADDR_W = 40,
  parameter int WIN_SHIFT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              guard_en,
  input  logic              init_load,
  input  logic [ADDR_W-WIN_SHIFT-1:0] init_base,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_from_dev,
  input  logic              req_aperture,
  input  logic              req_cfg,
  output logic              resp_valid,
  output logic              resp_block,
  output logic              viol_pulse,
  output logic [ADDR_W-1:0] viol_addr
);
  localparam int BASE_W = ADDR_W - WIN_SHIFT;

  logic [BASE_W-1:0] base_q;
  logic in_win, dev_mem_hit, ap_hit, dev_cfg_hit, block_now;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) base_q <= '0;
    else if (init_load) base_q <= init_base;

  assign in_win      = req_addr[ADDR_W-1:WIN_SHIFT] == base_q;
  assign dev_mem_hit = req_from_dev & ~req_cfg & in_win;
  assign ap_hit      = req_aperture & ~req_cfg & in_win;
  assign dev_cfg_hit = req_from_dev & req_cfg;
  assign block_now   = guard_en & (dev_mem_hit | ap_hit | dev_cfg_hit);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_block <= 1'b0;
      viol_pulse <= 1'b0;
      viol_addr  <= '0;
    end else begin
      resp_valid <= req_valid;
      resp_block <= req_valid & block_now;
      viol_pulse <= req_valid & block_now;
      if (req_valid & block_now) viol_addr <= req_addr;
    end
endmodule

// File: rtl/sl_region_guard_chk.sv
module sl_region_guard_chk #(
  parameter int ADDR_W = 40
) (
  input logic              clk,
  input logic              rst_n,
  input logic              guard_en,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_from_dev,
  input logic              req_aperture,
  input logic              req_cfg,
  input logic              resp_valid,
  input logic              resp_block,
  input logic              viol_pulse,
  input logic [ADDR_W-1:0] viol_addr
);
  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> !resp_valid && !viol_pulse); // R1
  AST_RESP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) req_valid |=> resp_valid); // R8
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n) !req_valid |=> !resp_valid && !resp_block && !viol_pulse); // R9
  AST_PULSE_MATCHES: assert property (@(posedge clk) disable iff (!rst_n) viol_pulse |-> resp_valid && resp_block); // R8
  AST_PULSE_ADDR: assert property (@(posedge clk) disable iff (!rst_n) req_valid ##1 viol_pulse |-> viol_addr == $past(req_addr)); // R8
  AST_DEV_CFG_BLOCK: assert property (@(posedge clk) disable iff (!rst_n) req_valid && guard_en && req_from_dev && req_cfg |=> resp_block); // R5
  AST_CPU_PLAIN_ALLOW: assert property (@(posedge clk) disable iff (!rst_n) req_valid && !req_from_dev && !req_aperture |=> !resp_block); // R6
  AST_DISABLED_ALLOW: assert property (@(posedge clk) disable iff (!rst_n) req_valid && !guard_en |=> !resp_block && !viol_pulse); // R7
endmodule

bind sl_region_guard sl_region_guard_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sl_region_guard_bench.sv
module sl_region_guard_bench;
  logic clk = 0, rst_n = 0;
  logic guard_en = 0, init_load = 0;
  logic [23:0] init_base = '0;
  logic req_valid = 0, req_from_dev = 0, req_aperture = 0, req_cfg = 0;
  logic [39:0] req_addr = '0;
  logic resp_valid, resp_block, viol_pulse;
  logic [39:0] viol_addr;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  sl_region_guard u_sl_region_guard (.*);

  // {en, dev, aperture, cfg, addr[39:0], expected block}
  localparam int NV = 14;
  localparam logic [44:0] VEC [NV] = '{
    {4'b1100, 40'h00_1234_0010, 1'b1}, // R3 device memory inside
    {4'b1100, 40'h00_1235_0000, 1'b0}, // R6 device memory just above
    {4'b1010, 40'h00_1234_FFFF, 1'b1}, // R4 CPU aperture, last byte
    {4'b1110, 40'h00_1234_8000, 1'b1}, // R4 device aperture inside
    {4'b1010, 40'h00_1233_0000, 1'b0}, // R6 CPU aperture outside
    {4'b1000, 40'h00_1234_0100, 1'b0}, // R6 CPU plain inside
    {4'b1101, 40'h00_0000_0000, 1'b1}, // R5 device cfg low address
    {4'b1101, 40'h00_1234_0000, 1'b1}, // R5 device cfg any address
    {4'b1011, 40'h00_1234_0000, 1'b0}, // R6 CPU cfg with aperture flag
    {4'b0100, 40'h00_1234_0010, 1'b0}, // R7 disabled device memory
    {4'b0101, 40'h00_0000_0040, 1'b0}, // R7 disabled device cfg
    {4'b0010, 40'h00_1234_0020, 1'b0}, // R7 disabled CPU aperture
    {4'b1100, 40'h00_1234_0000, 1'b1}, // R2 first byte of window
    {4'b1100, 40'h00_1233_FFFF, 1'b0}  // R2 byte below window
  };
  localparam int VREQ [NV] = '{3, 6, 4, 4, 6, 6, 5, 5, 6, 7, 7, 7, 2, 2};

  task automatic chk(input string req, input logic [39:0] act, input logic [39:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic en, dev, ap, cfg, input logic [39:0] a);
    @(negedge clk);
    guard_en = en; req_from_dev = dev; req_aperture = ap; req_cfg = cfg;
    req_addr = a; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic expect_resp(input string req, input logic blk, input logic [39:0] a);
    chk(req, {39'b0, resp_valid}, 40'd1);
    chk(req, {39'b0, resp_block}, {39'b0, blk});
    chk(req, {39'b0, viol_pulse}, {39'b0, blk});
    if (blk) chk(req, viol_addr, a);
  endtask

  initial begin
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #12;
    chk("R1 resp_valid in reset", {39'b0, resp_valid}, 40'd0);
    chk("R1 viol_pulse in reset", {39'b0, viol_pulse}, 40'd0);
    @(negedge clk); rst_n = 1;
    // R1: base is zero after reset, so device memory at 0x0000xxxx is blocked
    send(1, 1, 0, 0, 40'h00_0000_1234);
    expect_resp("R1 zero base", 1'b1, 40'h00_0000_1234);

    @(negedge clk); init_base = 24'h00_1234; init_load = 1;
    @(negedge clk); init_load = 0;

    for (int i = 0; i < NV; i++) begin
      send(VEC[i][44], VEC[i][43], VEC[i][42], VEC[i][41], VEC[i][40:1]);
      expect_resp($sformatf("R%0d vec%0d", VREQ[i], i), VEC[i][0], VEC[i][40:1]);
    end

    // R9: idle cycle leaves no response
    @(negedge clk);
    chk("R9 idle resp_valid", {39'b0, resp_valid}, 40'd0);
    chk("R9 idle viol_pulse", {39'b0, viol_pulse}, 40'd0);

    // R2: reload base; old window freed, new window blocked
    @(negedge clk); init_base = 24'h0A_BCDE; init_load = 1;
    @(negedge clk); init_load = 0;
    send(1, 1, 0, 0, 40'h00_1234_0010);
    expect_resp("R2 old window freed", 1'b0, 40'h0);
    send(1, 1, 0, 0, 40'h0A_BCDE_7777);
    expect_resp("R2 new window blocked", 1'b1, 40'h0A_BCDE_7777);

    // R8: back-to-back blocked requests each give one pulse
    @(negedge clk);
    guard_en = 1; req_from_dev = 1; req_aperture = 0; req_cfg = 1;
    req_addr = 40'h00_0000_0A00; req_valid = 1;
    @(negedge clk);
    expect_resp("R8 first pulse", 1'b1, 40'h00_0000_0A00);
    req_addr = 40'h00_0000_0B00;
    @(negedge clk);
    expect_resp("R8 second pulse", 1'b1, 40'h00_0000_0B00);
    req_valid = 0;
    @(negedge clk);
    chk("R8 pulse ends", {39'b0, viol_pulse}, 40'd0);

    // R1: a second reset returns the base to zero
    rst_n = 0;
    @(negedge clk); rst_n = 1;
    send(1, 1, 0, 0, 40'h0A_BCDE_7777);
    expect_resp("R1 base cleared", 1'b0, 40'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule